// File: doc/BRIEF.md
# Bus Memory Protection Checker

This block checks every bus access against a small table of region descriptors and reports whether the requesting master may perform it. A descriptor covers an address window with 32-byte granularity. It carries its own enable and a permission word. The permission word grants rights per master: the four low-numbered masters get a privileged field that splits user and supervisor rights and can be gated by a process identifier, and the four high-numbered masters get a plain read/write pair. The allow/deny answer is combinational, so it can sit in the address phase of an interconnect slave port.

When an access is denied, the block records the details of the first such error for the slave port that carried the access: the address, the master, an attribute, the direction and whether the address hit no region, one region or several. It keeps that record until software clears the port's flag. A narrow write port programs the descriptors, the global enable and the flag clears. Descriptor 0 cannot be reshaped by the core master, so the debug master always keeps its access path.

The access interface has no back-pressure. The checker never stalls, there is no ready signal, and `acc_valid` only qualifies error capture. The answer on `acc_allow` is given every cycle for whatever is on the access pins.

Top module: `bus_prot_checker`

## Requirements
- R1: A region covers the addresses from {start[31:5], 5'b00000} to {end[31:5], 5'b11111}. The low five bits written to the start and end words are ignored.
- R2: For masters 0 to 3, the permission word holds a 6-bit field at bit 6×m. Field bits [2:0] are the user code, with read weight 4, write weight 2 and execute weight 1, and 0 means no access. Bits [4:3] are the supervisor code. Bit 5 enables the process-ID gate. A user-mode access (`acc_priv`=0) is checked against the user code.
- R3: A supervisor access (`acc_priv`=1) from masters 0 to 3 uses the supervisor code: 0 grants read/write/execute, 1 grants read/execute, 2 grants read/write, and 3 uses the user code.
- R4: Masters 4 to 7 use bits 24+2×(m−4) (write enable) and 25+2×(m−4) (read enable). Execute is never granted to them, and `acc_priv` has no effect for them.
- R5: When a master's process-ID gate is set, the region hits only if `acc_pid` equals the region's PID on every bit where the region's PID mask is 0. A region that fails this check counts as not hit.
- R6: A region whose valid bit is 0 never hits. While the global enable is 0, every access is allowed and no error is captured.
- R7: When several valid regions hit, the access is allowed if any one of them grants the right. `acc_kind` is 0 for read, 1 for write and 2 for execute.
- R8: When master 0 writes descriptor 0, the start and end words and permission bits [11:6] stay unchanged. All other bits are written. Writes from any other master change every field.
- R9: A denied valid access with the port's flag clear sets the flag and records, one clock later, the address, the master, the attribute {acc_priv, not execute}, a write bit (1 only for writes) and the class: 0 no hit, 1 one region hit, 2 more than one region hit.
- R10: While a port's flag is set, its record holds. Writing 1 to the flag's clear bit drops it. If a clear and a new error on that port fall in the same cycle, the new error is captured.
- R11: Write port: with `cfg_ctrl`=1, data bit 0 is the global enable and bits 8+p clear the flag of port p. With `cfg_ctrl`=0, `cfg_word` picks 0 start, 1 end, 2 permissions, 3 {mask[23:16], pid[15:8], valid[0]}. At reset the global enable is 0, the flags are 0, and descriptor 0 is valid over the whole space with permissions 0xFF1C71C7. All other descriptors are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe of the configuration port |
| cfg_ctrl | input | 1 | 1 selects the control word, 0 a descriptor word |
| cfg_master | input | 3 | Master that issues the configuration write |
| cfg_region | input | $clog2(NUM_REGIONS) | Descriptor index |
| cfg_word | input | 2 | Descriptor word select |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present, qualifies error capture |
| acc_port | input | $clog2(NUM_PORTS) | Slave port that carries the access |
| acc_addr | input | 32 | Access address |
| acc_master | input | 3 | Requesting master |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_priv | input | 1 | 1 supervisor, 0 user |
| acc_pid | input | 8 | Process identifier |
| acc_allow | output | 1 | Access permitted (combinational) |
| err_flags | output | NUM_PORTS | Per-port error flag |
| err_sel | input | $clog2(NUM_PORTS) | Port whose record is shown |
| err_addr | output | 32 | Recorded address |
| err_master | output | 3 | Recorded master |
| err_attr | output | 2 | Recorded attribute |
| err_write | output | 1 | Recorded direction, 1 write |
| err_class | output | 2 | Recorded hit class |

## Verification
The assertions assume that `acc_kind` never takes the value 3, and that `acc_port`, `err_sel` and `cfg_region` stay inside their parameter ranges. They also assume that all inputs change only between clock edges. The bench applies every input on the falling edge, draws its random kinds from 0 to 2, and draws ports and region indices only from the legal ranges. Directed sequences cover the descriptor-0 lock, overlapping regions, a masked PID and a clear that coincides with a new error. A random phase then runs mixed accesses against the programmed table.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int ADDR_W       = 32;
  localparam int DATA_W       = 32;
  localparam int PID_W        = 8;
  localparam int MST_W        = 3;
  localparam int NUM_MST      = 8;
  localparam int NUM_PRIV_MST = 4;
  localparam int FIELD_W      = 6;
  localparam int PAIR_BASE    = 24;
  localparam int GRAN_W       = 5;
  localparam int CORE_MST     = 0;
  localparam int DBG_MST      = 1;
  localparam int CLR_BASE     = 8;
  localparam int PID_LSB      = 8;
  localparam int MASK_LSB     = 16;

  localparam logic [DATA_W-1:0] PERM_OPEN      = 32'hFF1C_71C7;
  localparam logic [DATA_W-1:0] DBG_FIELD_MASK = DATA_W'(6'h3F) << (DBG_MST * FIELD_W);

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_SINGLE = 2'd1,
    HIT_MULTI  = 2'd2
  } hit_class_e;

  typedef struct packed {
    logic                     valid;
    logic [ADDR_W-1:GRAN_W]   start_hi;
    logic [ADDR_W-1:GRAN_W]   end_hi;
    logic [DATA_W-1:0]        perm;
    logic [PID_W-1:0]         pid;
    logic [PID_W-1:0]         pid_mask;
  } desc_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MST_W-1:0]  master;
    logic [1:0]        attr;
    logic              is_write;
    hit_class_e        cls;
  } err_rec_t;

  function automatic desc_t reset_desc(input bit open);
    desc_t d;
    d = '0;
    if (open) begin
      d.valid  = 1'b1;
      d.end_hi = '1;
      d.perm   = PERM_OPEN;
    end
    return d;
  endfunction
endpackage

// File: rtl/mpu_desc_regs.sv
module mpu_desc_regs
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PORTS   = 2,
  localparam int RIDX_W     = $clog2(NUM_REGIONS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_ctrl,
  input  logic [MST_W-1:0]              cfg_master,
  input  logic [RIDX_W-1:0]             cfg_region,
  input  logic [1:0]                    cfg_word,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output desc_t [NUM_REGIONS-1:0]       desc_o,
  output logic                          glb_en_o,
  output logic [NUM_PORTS-1:0]          clr_o
);
  logic ctrl_wr;
  assign ctrl_wr = cfg_we && cfg_ctrl;
  assign clr_o   = ctrl_wr ? cfg_wdata[CLR_BASE +: NUM_PORTS] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glb_en_o <= 1'b0;
    else if (ctrl_wr) glb_en_o <= cfg_wdata[0];
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_desc
    localparam bit IS_ROOT = (r == 0);
    desc_t d_q;
    logic  sel;
    logic  locked;
    assign sel    = cfg_we && !cfg_ctrl && (cfg_region == RIDX_W'(r));
    // the core master may not reshape the root descriptor
    assign locked = IS_ROOT && (cfg_master == MST_W'(CORE_MST));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= reset_desc(IS_ROOT);
      end else if (sel) begin
        case (cfg_word)
          2'd0: if (!locked) d_q.start_hi <= cfg_wdata[ADDR_W-1:GRAN_W];
          2'd1: if (!locked) d_q.end_hi   <= cfg_wdata[ADDR_W-1:GRAN_W];
          2'd2: d_q.perm <= locked ? ((cfg_wdata & ~DBG_FIELD_MASK) | (d_q.perm & DBG_FIELD_MASK))
                                   : cfg_wdata;
          default: begin
            d_q.valid    <= cfg_wdata[0];
            d_q.pid      <= cfg_wdata[PID_LSB +: PID_W];
            d_q.pid_mask <= cfg_wdata[MASK_LSB +: PID_W];
          end
        endcase
      end
    end
    assign desc_o[r] = d_q;
  end
endmodule

// File: rtl/mpu_region_eval.sv
module mpu_region_eval
  import mpu_pkg::*;
(
  input  desc_t              desc,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [MST_W-1:0]   acc_master,
  input  logic [1:0]         acc_kind,
  input  logic               acc_priv,
  input  logic [PID_W-1:0]   acc_pid,
  output logic               hit,
  output logic               grant
);
  logic [FIELD_W-1:0] fld;
  logic [1:0]         pair;
  logic [2:0]         rights;   // {read, write, execute}
  logic [2:0]         need;
  logic               gate_on;
  logic               pid_ok;
  logic               in_range;

  always_comb begin
    fld  = '0;
    pair = '0;
    for (int i = 0; i < NUM_PRIV_MST; i++)
      if (acc_master == MST_W'(i)) fld = desc.perm[i*FIELD_W +: FIELD_W];
    for (int j = 0; j < NUM_MST - NUM_PRIV_MST; j++)
      if (acc_master == MST_W'(j + NUM_PRIV_MST)) pair = desc.perm[PAIR_BASE + 2*j +: 2];
  end

  always_comb begin
    if (acc_master < MST_W'(NUM_PRIV_MST)) begin
      gate_on = fld[5];
      if (acc_priv) begin
        case (fld[4:3])
          2'd0:    rights = 3'b111;
          2'd1:    rights = 3'b101;
          2'd2:    rights = 3'b110;
          default: rights = fld[2:0];
        endcase
      end else begin
        rights = fld[2:0];
      end
    end else begin
      gate_on = 1'b0;
      rights  = {pair[1], pair[0], 1'b0};
    end
  end

  always_comb begin
    case (acc_kind)
      KIND_WRITE: need = 3'b010;
      KIND_FETCH: need = 3'b001;
      default:    need = 3'b100;
    endcase
  end

  assign in_range = (acc_addr[ADDR_W-1:GRAN_W] >= desc.start_hi) &&
                    (acc_addr[ADDR_W-1:GRAN_W] <= desc.end_hi);
  assign pid_ok   = !gate_on || (((acc_pid ^ desc.pid) & ~desc.pid_mask) == '0);
  assign hit      = desc.valid && in_range && pid_ok;
  assign grant    = hit && |(rights & need);
endmodule

// File: rtl/mpu_err_log.sv
module mpu_err_log
  import mpu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  logic     clr,
  input  err_rec_t rec_in,
  output logic     flag,
  output err_rec_t rec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      rec  <= '0;
    end else if (capture && (!flag || clr)) begin
      flag <= 1'b1;
      rec  <= rec_in;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_prot_checker.sv
module bus_prot_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PORTS   = 2,
  localparam int RIDX_W     = $clog2(NUM_REGIONS),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_ctrl,
  input  logic [MST_W-1:0]     cfg_master,
  input  logic [RIDX_W-1:0]    cfg_region,
  input  logic [1:0]           cfg_word,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 acc_valid,
  input  logic [PORT_W-1:0]    acc_port,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [MST_W-1:0]     acc_master,
  input  logic [1:0]           acc_kind,
  input  logic                 acc_priv,
  input  logic [PID_W-1:0]     acc_pid,
  output logic                 acc_allow,
  output logic [NUM_PORTS-1:0] err_flags,
  input  logic [PORT_W-1:0]    err_sel,
  output logic [ADDR_W-1:0]    err_addr,
  output logic [MST_W-1:0]     err_master,
  output logic [1:0]           err_attr,
  output logic                 err_write,
  output logic [1:0]           err_class
);
  desc_t    [NUM_REGIONS-1:0] desc_q;
  err_rec_t [NUM_PORTS-1:0]   rec_q;
  logic     [NUM_PORTS-1:0]   clr;
  logic     [NUM_REGIONS-1:0] hit_v;
  logic     [NUM_REGIONS-1:0] grant_v;
  logic                       glb_en_q;
  logic                       seen, multi;
  hit_class_e                 cls_c;
  err_rec_t                   rec_in;
  logic                       deny;

  mpu_desc_regs #(.NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS)) u_desc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
    .cfg_master(cfg_master), .cfg_region(cfg_region), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .desc_o(desc_q), .glb_en_o(glb_en_q), .clr_o(clr)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_eval
    mpu_region_eval u_eval (
      .desc(desc_q[r]), .acc_addr(acc_addr), .acc_master(acc_master),
      .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_pid(acc_pid),
      .hit(hit_v[r]), .grant(grant_v[r])
    );
  end

  // hit classification: none, exactly one, or overlapping
  always_comb begin
    seen  = 1'b0;
    multi = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hit_v[r]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
    cls_c = multi ? HIT_MULTI : (seen ? HIT_SINGLE : HIT_NONE);
  end

  assign acc_allow = !glb_en_q || (|grant_v);
  assign deny      = acc_valid && !acc_allow;

  always_comb begin
    rec_in.addr     = acc_addr;
    rec_in.master   = acc_master;
    rec_in.attr     = {acc_priv, acc_kind != KIND_FETCH};
    rec_in.is_write = (acc_kind == KIND_WRITE);
    rec_in.cls      = cls_c;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mpu_err_log u_log (
      .clk(clk), .rst_n(rst_n),
      .capture(deny && (acc_port == PORT_W'(p))),
      .clr(clr[p]), .rec_in(rec_in),
      .flag(err_flags[p]), .rec(rec_q[p])
    );
  end

  assign err_addr   = rec_q[err_sel].addr;
  assign err_master = rec_q[err_sel].master;
  assign err_attr   = rec_q[err_sel].attr;
  assign err_write  = rec_q[err_sel].is_write;
  assign err_class  = rec_q[err_sel].cls;
endmodule

// File: rtl/bus_prot_checker_sva.sv
module bus_prot_checker_sva
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PORTS   = 2,
  localparam int RIDX_W     = $clog2(NUM_REGIONS),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic                       cfg_ctrl,
  input logic [MST_W-1:0]           cfg_master,
  input logic [RIDX_W-1:0]          cfg_region,
  input logic [1:0]                 cfg_word,
  input logic [DATA_W-1:0]          cfg_wdata,
  input logic                       acc_valid,
  input logic [PORT_W-1:0]          acc_port,
  input logic [ADDR_W-1:0]          acc_addr,
  input logic                       acc_allow,
  input logic                       glb_en,
  input logic [NUM_PORTS-1:0]       flags,
  input err_rec_t [NUM_PORTS-1:0]   recs,
  input desc_t [NUM_REGIONS-1:0]    descs
);
  logic root_core_wr;
  assign root_core_wr = cfg_we && !cfg_ctrl && (cfg_region == '0) &&
                        (cfg_master == MST_W'(CORE_MST));

  assert_open_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> acc_allow);

  assert_root_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    root_core_wr && (cfg_word[1] == 1'b0) |=>
      $stable(descs[0].start_hi) && $stable(descs[0].end_hi));

  assert_root_dbg_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    root_core_wr && (cfg_word == 2'd2) |=> $stable(descs[0].perm[11:6]));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    logic clr_p;
    assign clr_p = cfg_we && cfg_ctrl && cfg_wdata[CLR_BASE + p];

    assert_first_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_allow && (acc_port == PORT_W'(p)) && !flags[p] |=>
        flags[p] && (recs[p].addr == $past(acc_addr)));

    assert_class_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] |-> (recs[p].cls != 2'd3));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && !clr_p |=> flags[p]);

    assert_record_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && !clr_p |=> $stable(recs[p]));
  end
endmodule

bind bus_prot_checker bus_prot_checker_sva #(
  .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
  .cfg_master(cfg_master), .cfg_region(cfg_region), .cfg_word(cfg_word),
  .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_port(acc_port),
  .acc_addr(acc_addr), .acc_allow(acc_allow), .glb_en(glb_en_q),
  .flags(err_flags), .recs(rec_q), .descs(desc_q)
);

// File: tb/bus_prot_checker_tb.sv
`timescale 1ns/1ps
module bus_prot_checker_tb;
  localparam int NR = 4;
  localparam int NP = 2;
  localparam int RW = $clog2(NR);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 0, cfg_ctrl = 0;
  logic [2:0]    cfg_master = 0;
  logic [RW-1:0] cfg_region = 0;
  logic [1:0]    cfg_word = 0;
  logic [31:0]   cfg_wdata = 0;
  logic          acc_valid = 0;
  logic [PW-1:0] acc_port = 0;
  logic [31:0]   acc_addr = 0;
  logic [2:0]    acc_master = 0;
  logic [1:0]    acc_kind = 0;
  logic          acc_priv = 0;
  logic [7:0]    acc_pid = 0;
  logic [PW-1:0] err_sel = 0;
  logic          acc_allow;
  logic [NP-1:0] err_flags;
  logic [31:0]   err_addr;
  logic [2:0]    err_master;
  logic [1:0]    err_attr;
  logic          err_write;
  logic [1:0]    err_class;

  bus_prot_checker #(.NUM_REGIONS(NR), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
    .cfg_master(cfg_master), .cfg_region(cfg_region), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_port(acc_port),
    .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_pid(acc_pid), .acc_allow(acc_allow),
    .err_flags(err_flags), .err_sel(err_sel), .err_addr(err_addr),
    .err_master(err_master), .err_attr(err_attr), .err_write(err_write),
    .err_class(err_class)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R11";

  // reference state
  logic [31:0] m_lo[NR], m_hi[NR], m_perm[NR];
  logic        m_val[NR];
  logic [7:0]  m_pid[NR], m_mask[NR];
  logic        m_glb;
  logic        m_flag[NP];
  logic [31:0] m_addr[NP];
  logic [2:0]  m_mst[NP];
  logic [1:0]  m_attr[NP], m_cls[NP];
  logic        m_wr[NP];

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_lo[r] = 0; m_hi[r] = (r == 0) ? 32'hFFFF_FFFF : 32'h1F;
      m_perm[r] = (r == 0) ? 32'hFF1C_71C7 : 0;
      m_val[r] = (r == 0); m_pid[r] = 0; m_mask[r] = 0;
    end
    m_glb = 0;
    for (int p = 0; p < NP; p++) begin
      m_flag[p] = 0; m_addr[p] = 0; m_mst[p] = 0; m_attr[p] = 0; m_cls[p] = 0; m_wr[p] = 0;
    end
  endtask

  function automatic void model_eval(output logic allow, output int hits);
    int rights, need, fld, sc, b;
    logic any;
    any = 0; hits = 0;
    need = (acc_kind == 1) ? 2 : (acc_kind == 2) ? 1 : 4;
    for (int r = 0; r < NR; r++) begin
      if (!m_val[r] || acc_addr < m_lo[r] || acc_addr > m_hi[r]) continue;
      if (acc_master < 4) begin
        fld = int'((m_perm[r] >> (6 * int'(acc_master))) & 32'h3F);
        sc = (fld >> 3) & 3;
        if (!acc_priv || sc == 3) rights = fld & 7;
        else rights = (sc == 0) ? 7 : (sc == 1) ? 5 : 6;
        if (((fld >> 5) & 1) == 1 && ((acc_pid ^ m_pid[r]) & ~m_mask[r]) != 0) continue;
      end else begin
        b = 24 + 2 * (int'(acc_master) - 4);
        rights = 4 * int'(m_perm[r][b+1]) + 2 * int'(m_perm[r][b]);
      end
      hits++;
      if ((rights & need) != 0) any = 1;
    end
    allow = !m_glb || any;
  endfunction

  task automatic fail(string what, logic [31:0] got, logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
  endtask

  task automatic tick();
    logic a;
    int h, p;
    logic [NP-1:0] fl;
    logic [NP-1:0] clr;
    err_sel = PW'(vectors % NP);
    #1;
    vectors++;
    model_eval(a, h);
    p = int'(err_sel);
    for (int q = 0; q < NP; q++) fl[q] = m_flag[q];
    if (acc_allow !== a) fail("allow", 32'(acc_allow), 32'(a));
    if (err_flags !== fl) fail("flags", 32'(err_flags), 32'(fl));
    if (err_addr !== m_addr[p]) fail("err addr", err_addr, m_addr[p]);
    if (err_master !== m_mst[p]) fail("err master", 32'(err_master), 32'(m_mst[p]));
    if (err_attr !== m_attr[p]) fail("err attr", 32'(err_attr), 32'(m_attr[p]));
    if (err_write !== m_wr[p]) fail("err write", 32'(err_write), 32'(m_wr[p]));
    if (err_class !== m_cls[p]) fail("err class", 32'(err_class), 32'(m_cls[p]));
    @(posedge clk);
    if (!rst_n) begin
      model_reset();
    end else begin
      clr = (cfg_we && cfg_ctrl) ? cfg_wdata[8 +: NP] : '0;
      for (int q = 0; q < NP; q++) begin
        if (acc_valid && !a && int'(acc_port) == q && (!m_flag[q] || clr[q])) begin
          m_flag[q] = 1; m_addr[q] = acc_addr; m_mst[q] = acc_master;
          m_attr[q] = {acc_priv, acc_kind != 2}; m_wr[q] = (acc_kind == 1);
          m_cls[q] = (h == 0) ? 2'd0 : (h == 1) ? 2'd1 : 2'd2;
        end else if (clr[q]) m_flag[q] = 0;
      end
      if (cfg_we && cfg_ctrl) m_glb = cfg_wdata[0];
      else if (cfg_we) begin
        int r;
        logic lock;
        r = int'(cfg_region);
        lock = (r == 0) && (cfg_master == 0);
        case (cfg_word)
          0: if (!lock) m_lo[r] = cfg_wdata & 32'hFFFF_FFE0;
          1: if (!lock) m_hi[r] = cfg_wdata | 32'h1F;
          2: m_perm[r] = lock ? ((cfg_wdata & ~32'hFC0) | (m_perm[r] & 32'hFC0)) : cfg_wdata;
          default: begin
            m_val[r] = cfg_wdata[0]; m_pid[r] = cfg_wdata[15:8]; m_mask[r] = cfg_wdata[23:16];
          end
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_we = 0; cfg_ctrl = 0; acc_valid = 0;
  endtask

  task automatic wr_desc(input int m, input int r, input int w, input logic [31:0] d);
    cfg_we = 1; cfg_ctrl = 0; cfg_master = 3'(m); cfg_region = RW'(r);
    cfg_word = 2'(w); cfg_wdata = d;
    tick(); quiet();
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    cfg_we = 1; cfg_ctrl = 1; cfg_wdata = d;
    tick(); quiet();
  endtask

  task automatic set_acc(input int port, input logic [31:0] a, input int m,
                         input int k, input logic pv, input logic [7:0] pid);
    acc_valid = 1; acc_port = PW'(port); acc_addr = a; acc_master = 3'(m);
    acc_kind = 2'(k); acc_priv = pv; acc_pid = pid;
  endtask

  task automatic access(input int port, input logic [31:0] a, input int m,
                        input int k, input logic pv, input logic [7:0] pid);
    set_acc(port, a, m, k, pv, pid);
    tick(); quiet();
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    cur_req = "R11";
    tick(); tick();
    rst_n = 1;
    tick();
    access(0, 32'h1234_5678, 2, 1, 0, 0);

    cur_req = "R6";                      // disable root region while global is off
    wr_desc(1, 0, 3, 0);
    access(0, 32'h0000_0040, 5, 0, 0, 0);
    wr_ctrl(1);
    access(0, 32'h0000_0040, 5, 0, 0, 0);  // no hit: class 0
    tick();

    cur_req = "R10";
    access(0, 32'h0000_0080, 6, 1, 1, 0);  // record must stay
    tick();
    wr_ctrl(32'h0000_0101);
    tick();

    cur_req = "R1";
    wr_desc(1, 1, 0, 32'h0000_1010);
    wr_desc(1, 1, 1, 32'h0000_1F00);
    wr_desc(1, 1, 2, 32'h0000_0014 | (32'h19 << 12) | (32'h1 << 25) | (32'h1 << 26));
    wr_desc(1, 1, 3, 32'h1);
    access(1, 32'h0000_1000, 0, 0, 0, 0);
    access(1, 32'h0000_1F1F, 0, 0, 0, 0);
    access(1, 32'h0000_1F20, 0, 0, 0, 0);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R2";
    access(0, 32'h0000_1100, 0, 1, 0, 0);
    tick();
    access(1, 32'h0000_1100, 2, 2, 0, 0);
    access(1, 32'h0000_1100, 2, 0, 0, 0);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R3";
    access(0, 32'h0000_1100, 0, 1, 1, 0);
    access(0, 32'h0000_1100, 0, 2, 1, 0);
    tick();
    access(1, 32'h0000_1100, 2, 2, 1, 0);
    access(1, 32'h0000_1100, 2, 0, 1, 0);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R4";
    access(0, 32'h0000_1100, 4, 0, 0, 0);
    access(0, 32'h0000_1100, 4, 0, 1, 0);
    access(0, 32'h0000_1100, 4, 1, 0, 0);
    tick();
    access(1, 32'h0000_1100, 4, 2, 1, 0);
    access(1, 32'h0000_1100, 5, 1, 0, 0);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R5";
    wr_desc(1, 2, 0, 32'h0000_2000);
    wr_desc(1, 2, 1, 32'h0000_2FFF);
    wr_desc(1, 2, 2, 32'h27 << 18);
    wr_desc(1, 2, 3, 32'h000F_5A01);
    access(0, 32'h0000_2200, 3, 1, 0, 8'h53);
    access(0, 32'h0000_2200, 3, 1, 0, 8'h6A);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R7";
    wr_desc(1, 3, 0, 32'h0000_1800);
    wr_desc(1, 3, 1, 32'h0000_1FFF);
    wr_desc(1, 3, 2, 32'h0000_0002);
    wr_desc(1, 3, 3, 32'h1);
    access(0, 32'h0000_1900, 0, 1, 0, 0);
    access(0, 32'h0000_1900, 0, 0, 0, 0);
    access(0, 32'h0000_1900, 0, 2, 0, 0);  // overlap deny: class 2
    tick();

    cur_req = "R10";                      // clear and new error together
    cfg_we = 1; cfg_ctrl = 1; cfg_wdata = 32'h0000_0101;
    set_acc(0, 32'h0000_1F80, 4, 2, 0, 0);
    tick(); quiet();
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R8";
    wr_desc(0, 0, 0, 32'h0000_4000);
    wr_desc(0, 0, 1, 32'h0000_0000);
    wr_desc(0, 0, 2, 32'h0000_0000);
    wr_desc(0, 0, 3, 32'h0000_0001);
    access(0, 32'hFFFF_0000, 1, 0, 0, 0);
    access(1, 32'hFFFF_0000, 0, 0, 0, 0);
    tick();
    wr_ctrl(32'h0000_0301);
    wr_desc(1, 0, 0, 32'h0000_4000);
    access(0, 32'h0000_0100, 1, 0, 0, 0);
    tick();
    wr_ctrl(32'h0000_0301);

    cur_req = "R9";                       // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if ((i % 23) == 0) begin
        cfg_we = 1; cfg_ctrl = 1; cfg_wdata = 32'h0000_0001 | (32'($urandom_range(0, 3)) << 8);
      end
      set_acc(int'($urandom_range(0, NP - 1)), 32'($urandom_range(0, 32'h5FFF)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 2)),
              1'($urandom_range(0, 1)),
              ($urandom_range(0, 1) == 1) ? 8'h5A : 8'($urandom_range(0, 255)));
      acc_valid = 1'($urandom_range(0, 3) != 0);
      tick(); quiet();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule